// File: doc/BRIEF.md
# Packed Vector Register Allocation Decoder

This block turns one packed configuration word into the per-register element width and element type fields of a 32-entry vector register file. The word is cut into 5-bit fields, one per datatype. A nonzero field gives the number of the highest register that holds that datatype. The registers form contiguous runs that stack upward in datatype order. The lowest run always starts at v0. Every register above the top run is disabled.

A request is a single-cycle pulse on `cfg_req`. The block checks the word, and when the word is legal it presents the new width and type vectors together with a one-cycle reconfiguration strobe. It also reports the maximum vector length (MVL), which external logic computes from the registered width vector. A short immediate form carries only a 5-bit value.

When the word is illegal, the block raises an illegal-instruction flag and the stored configuration does not change.

Top module: `vcfg_unpack`

## Requirements
- R1: Field k sits at bits [5k+4:5k]. For k = 0..8 the datatype order is X8, X16, X32, F16, F32, F64, X64, F128, X128. The default build (XLEN=64) has fields 0..7. The type codes are X8=1000, X16=1001, X32=1010, X64=1011, X128=1100, F16=0001, F32=0010, F64=0011 and F128=0100.
- R2: The lowest nonzero field owns registers v0 up to its value. Each higher nonzero field owns the registers from one above the previous nonzero value up to its own value. The word with X32=1, F32=12, F64=18 gives v0-v1 type 1010, v2-v12 type 0010 and v13-v18 type 0011.
- R3: Every register above the highest nonzero field gets width 0000 and type 0000.
- R4: An integer type records a width equal to its type code. A float type records its code with bit 3 set: F16 gives 1001, F32 gives 1010, F64 gives 1011 and F128 gives 1100.
- R5: A nonzero field that is not strictly greater than every lower nonzero field makes the request illegal.
- R6: Any nonzero bit above the used fields (bits 63..40 by default) makes the request illegal.
- R7: A nonzero field for a datatype outside the supported-type mask is illegal. The default mask excludes F128 (field 7).
- R8: An all-zero word is legal. It disables every register and returns an MVL of 0.
- R9: In immediate form (`cfg_imm`=1), only `cfg_val[4:0]` is used, and it is taken as the X8 field. All other bits are ignored.
- R10: A legal request gives `cfg_wr`=1 for exactly one cycle, one cycle after the request, with the new vectors on `wr_width`/`wr_type`. This strobe zeroes the data registers, clears the predicate count and reloads the vector length. In the same cycle, `rsp_mvl` equals `mvl_in` for a nonzero word.
- R11: An illegal request gives `rsp_illegal`=1 and `cfg_wr`=0. `wr_width` and `wr_type` keep their earlier values, and `rsp_mvl` is 0.
- R12: `rsp_vld` is high exactly one cycle after each request. `rsp_mvl` is 0 whenever `rsp_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | One-cycle decode request |
| cfg_imm | input | 1 | Immediate form; only the low 5 bits are used |
| cfg_val | input | XLEN | Packed configuration word |
| mvl_in | input | MVLW | MVL computed externally from `wr_width` |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_illegal | output | 1 | Request was rejected |
| rsp_mvl | output | MVLW | Returned MVL |
| cfg_wr | output | 1 | Reconfiguration strobe: write fields, zero data registers, clear predicates, reload length |
| wr_width | output | NREG*4 | Width field per register; register r at bits [4r+3:4r] |
| wr_type | output | NREG*4 | Type field per register; register r at bits [4r+3:4r] |

## Verification
The bench targets these cases and the defect each one exposes:
- The worked allocation, where a decoder that does not stack runs upward misplaces the boundaries at v1, v12 and v18.
- Two equal or descending fields. A design that compared with "greater or equal", or only against the adjacent field, would accept them.
- A set bit in the reserved top bits, and a field for the unsupported F128 type. A careless decoder would silently honour either one.
- Immediate requests with garbage in the upper bits, which must be ignored.
- The all-zero word, which must return MVL 0 even though `mvl_in` is nonzero.
- Random legal and illegal words, each compared with an independent range-filling model, including the check that a rejected request leaves the previous configuration in place.

// File: rtl/vcfg_unpack.sv
module vcfg_unpack #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter logic [8:0] SUPP = 9'h07F,
  parameter int MVLW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_imm,
  input  logic [XLEN-1:0]   cfg_val,
  input  logic [MVLW-1:0]   mvl_in,
  output logic              rsp_vld,
  output logic              rsp_illegal,
  output logic [MVLW-1:0]   rsp_mvl,
  output logic              cfg_wr,
  output logic [NREG*4-1:0] wr_width,
  output logic [NREG*4-1:0] wr_type
);
  localparam int FW   = 5;
  localparam int NFLD = (XLEN >= 128) ? 9 : (XLEN >= 64) ? 8 : 6;
  localparam int USED = NFLD * FW;

  function automatic logic [3:0] tcode(input int k);
    case (k)
      0: tcode = 4'b1000;
      1: tcode = 4'b1001;
      2: tcode = 4'b1010;
      3: tcode = 4'b0001;
      4: tcode = 4'b0010;
      5: tcode = 4'b0011;
      6: tcode = 4'b1011;
      7: tcode = 4'b0100;
      default: tcode = 4'b1100;
    endcase
  endfunction

  logic [XLEN-1:0]   val;
  logic [FW-1:0]     fld [NFLD];
  logic              bad_order, bad_type, bad_range, bad_resv, illegal;
  logic [NREG*4-1:0] nw, nt;
  logic              any_q;

  assign val = cfg_imm ? {{(XLEN-FW){1'b0}}, cfg_val[FW-1:0]} : cfg_val;
  assign bad_resv = |val[XLEN-1:USED];
  assign illegal = bad_order | bad_type | bad_range | bad_resv;

  always_comb begin
    logic [FW-1:0] prev;
    logic          seen;
    prev = '0;
    seen = 1'b0;
    bad_order = 1'b0;
    bad_type  = 1'b0;
    bad_range = 1'b0;
    for (int k = 0; k < NFLD; k++) begin
      fld[k] = val[k*FW +: FW];
      if (fld[k] != '0) begin
        if (seen && fld[k] <= prev) bad_order = 1'b1;
        if (!SUPP[k]) bad_type = 1'b1;
        if (int'(fld[k]) >= NREG) bad_range = 1'b1;
        prev = fld[k];
        seen = 1'b1;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      logic [3:0] t;
      t = 4'b0000;
      for (int k = NFLD - 1; k >= 0; k--)
        if (fld[k] != '0 && r <= int'(fld[k])) t = tcode(k);
      nt[r*4 +: 4] = t;
      nw[r*4 +: 4] = (t == 4'b0000) ? 4'b0000 : (t | 4'b1000);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld     <= 1'b0;
      rsp_illegal <= 1'b0;
      cfg_wr      <= 1'b0;
      any_q       <= 1'b0;
      wr_width    <= '0;
      wr_type     <= '0;
    end else begin
      rsp_vld     <= cfg_req;
      rsp_illegal <= cfg_req & illegal;
      cfg_wr      <= cfg_req & ~illegal;
      if (cfg_req && !illegal) begin
        any_q    <= |val;
        wr_width <= nw;
        wr_type  <= nt;
      end
    end
  end

  assign rsp_mvl = (rsp_vld && !rsp_illegal && any_q) ? mvl_in : '0;
endmodule

module vcfg_unpack_chk #(
  parameter int NREG = 32,
  parameter int MVLW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_req,
  input logic              rsp_vld,
  input logic              rsp_illegal,
  input logic [MVLW-1:0]   rsp_mvl,
  input logic              cfg_wr,
  input logic [NREG*4-1:0] wr_width,
  input logic [NREG*4-1:0] wr_type
);
  // R12
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> rsp_vld);
  // R12
  rsp_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req |=> !rsp_vld);
  // R12
  mvl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> rsp_mvl == '0);
  // R11
  illegal_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> !cfg_wr && rsp_mvl == '0);
  // R11
  hold_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |-> $stable(wr_width) && $stable(wr_type));
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> rsp_vld && !rsp_illegal);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    // R4
    width_of_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_type[r*4 +: 4] != 4'b0000) |-> wr_width[r*4+3]);
    if (r < NREG - 1) begin : g_up
      // R3
      disabled_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_type[r*4 +: 4] == 4'b0000) |-> (wr_type[(r+1)*4 +: 4] == 4'b0000));
    end
  end
endmodule

bind vcfg_unpack vcfg_unpack_chk #(.NREG(NREG), .MVLW(MVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .rsp_vld(rsp_vld),
  .rsp_illegal(rsp_illegal), .rsp_mvl(rsp_mvl), .cfg_wr(cfg_wr),
  .wr_width(wr_width), .wr_type(wr_type)
);

// File: tb/vcfg_unpack_tb.sv
`timescale 1ns/1ps
module vcfg_unpack_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_req = 1'b0;
  logic         cfg_imm = 1'b0;
  logic [63:0]  cfg_val = '0;
  logic [15:0]  mvl_in;
  logic         rsp_vld, rsp_illegal, cfg_wr;
  logic [15:0]  rsp_mvl;
  logic [127:0] wr_width, wr_type;

  int n_chk = 0;
  int n_bad = 0;
  logic [127:0] ew = '0, et = '0;

  always #4 clk = ~clk;

  vcfg_unpack u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_imm(cfg_imm),
    .cfg_val(cfg_val), .mvl_in(mvl_in), .rsp_vld(rsp_vld),
    .rsp_illegal(rsp_illegal), .rsp_mvl(rsp_mvl), .cfg_wr(cfg_wr),
    .wr_width(wr_width), .wr_type(wr_type)
  );

  function automatic logic [15:0] mvl_of(input logic [127:0] w);
    int n = 0;
    for (int r = 0; r < 32; r++) if (w[r*4 +: 4] != 4'b0000) n++;
    return 16'(4 + 2 * n);
  endfunction

  assign mvl_in = mvl_of(wr_width);

  function automatic logic [3:0] code_of(input int k);
    logic [3:0] c [9] = '{4'h8, 4'h9, 4'hA, 4'h1, 4'h2, 4'h3, 4'hB, 4'h4, 4'hC};
    return c[k];
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic imm, input logic [63:0] v, output bit ill,
                       output logic [127:0] w, output logic [127:0] t);
    logic [63:0] x;
    int lo, top;
    x = imm ? {59'd0, v[4:0]} : v;
    ill = (x[63:40] != 0);
    w = '0; t = '0; lo = 0; top = -1;
    for (int k = 0; k < 8; k++) begin
      int f;
      f = int'(x[k*5 +: 5]);
      if (f != 0) begin
        if (f <= top) ill = 1;
        if (k == 7) ill = 1;
        for (int r = lo; r <= f; r++) begin
          t[r*4 +: 4] = code_of(k);
          w[r*4 +: 4] = code_of(k) | 4'b1000;
        end
        lo = f + 1; top = f;
      end
    end
  endtask

  task automatic run(input string tag, input logic imm, input logic [63:0] v);
    bit ill;
    logic [127:0] w, t;
    model(imm, v, ill, w, t);
    @(negedge clk);
    cfg_req = 1'b1; cfg_imm = imm; cfg_val = v;
    @(negedge clk);
    cfg_req = 1'b0; cfg_val = $urandom();
    chk({tag, " R12 rsp_vld"}, 128'(rsp_vld), 128'(1));
    chk({tag, " R5/R6/R7 illegal"}, 128'(rsp_illegal), 128'(ill));
    chk({tag, " R10/R11 cfg_wr"}, 128'(cfg_wr), 128'(!ill));
    if (!ill) begin ew = w; et = t; end
    chk({tag, " R1/R2/R3 type"}, wr_type, et);
    chk({tag, " R4 width"}, wr_width, ew);
    chk({tag, " R8/R10 mvl"}, 128'(rsp_mvl),
        (ill || ew == '0) ? 128'(0) : 128'(mvl_of(ew)));
    @(negedge clk);
    chk({tag, " R10 one-cycle strobe"}, 128'({rsp_vld, cfg_wr}), 128'(0));
    chk({tag, " R12 idle mvl"}, 128'(rsp_mvl), 128'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R12 reset rsp_vld", 128'(rsp_vld), 128'(0));
    chk("R3 reset width", wr_width, 128'(0));
    chk("R10 reset cfg_wr", 128'(cfg_wr), 128'(0));
    rst_n = 1'b1;

    run("worked", 1'b0, (64'd1 << 10) | (64'd12 << 20) | (64'd18 << 25));
    chk("R2 v1 type", 128'(wr_type[7:4]), 128'(4'hA));
    chk("R2 v2 type", 128'(wr_type[11:8]), 128'(4'h2));
    chk("R2 v13 width", 128'(wr_width[55:52]), 128'(4'hB));
    chk("R3 v19 type", 128'(wr_type[79:76]), 128'(4'h0));
    run("R5 descend", 1'b0, 64'd5 | (64'd3 << 5));
    run("R5 equal", 1'b0, 64'd4 | (64'd4 << 5));
    run("R6 reserved", 1'b0, 64'd7 | (64'd1 << 63));
    run("R7 f128", 1'b0, 64'd2 | (64'd20 << 35));
    run("R8 zero", 1'b0, 64'd0);
    run("R9 imm", 1'b1, 64'hFFFF_FFFF_FFFF_FFE3);
    run("R1 x64 top", 1'b0, (64'd1 << 5) | (64'd31 << 30));

    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      int cur;
      v = '0; cur = 0;
      if (i % 4 == 3) begin
        v = {$urandom(), $urandom()};
        if (i % 8 != 7) v[63:40] = '0;
      end else begin
        for (int k = 0; k < 8; k++)
          if ($urandom() % 2 == 1 && cur < 31) begin
            cur = cur + 1 + int'($urandom() % 6);
            if (cur > 31) cur = 31;
            v[k*5 +: 5] = 5'(cur);
          end
      end
      run("random", (i % 10 == 5) ? 1'b1 : 1'b0, v);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule